// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

The unit watches every bus access and decides, in the same cycle, whether it breaks the rules of the protection regions. There are sixteen regions. Each one has a size-aligned base address, a power-of-two size from 1 KB to 1 MB, an enable bit and two permission bits: one forbids writes and one forbids user-mode accesses. A separate rule guards the peripheral space, which is the top 256 MB of the address map (address bits [31:28] equal to 4'hF). The same two permission bits apply there.

A violating access produces a one-cycle abort pulse in the cycle after the valid strobe. The first fault is latched into status registers that software can read: the faulting address, whether it was a write, whether it was a user access, and which rule caught it. Later faults cannot overwrite the saved fault. Instead they set an overrun flag, which stays set until software clears the status.

The fault status is handled by a two-state machine. FS_EMPTY means no fault is held. On a violating access it takes the *capture* transition to FS_HELD. FS_HELD stays in place while further faults arrive (the *overrun* self-loop). A write to the status word clears it: this is the *clear* transition back to FS_EMPTY, or the *clear-and-recapture* self-loop when a new fault arrives in the same cycle.

Top module: `mpu_top`

## Requirements
- R1: After reset, `abort_o` is 0, every region is disabled, the control word (cfg address 16) reads 0 and the fault info word (cfg address 18) reads 0.
- R2: A cfg write to address i (0..15) programs region i with the fields base=wdata[31:10], size code=wdata[9:6], enable=wdata[2], no_user=wdata[1] and no_write=wdata[0]. A write to address 16 sets global enable=wdata[0], peripheral no_write=wdata[1] and peripheral no_user=wdata[2].
- R3: A write access (`acc_write`=1) that hits an enabled region with no_write set aborts. A read access to the same region does not abort.
- R4: A user access (`acc_user`=1) that hits an enabled region with no_user set aborts. A privileged access to the same region does not abort.
- R5: A region covers 1024<<code bytes, and codes above 10 act as 10. Base bits below the region size are ignored in the compare.
- R6: When several enabled regions contain an address, the lowest-numbered one alone decides the permissions. An address that no enabled region contains is allowed.
- R7: An address with bits [31:28]=4'hF is also checked against the peripheral rule. An abort here that no region caused reports index 16.
- R8: With global enable cleared, no access aborts.
- R9: `abort_o` is a one-cycle pulse. It is high in the cycle after a valid violating access and is never high without a valid access in the previous cycle.
- R10: The first fault is latched. Cfg address 17 reads the fault address. Cfg address 18 reads {overrun[9], index[8:4], user[3], write[2], periph-only[1], valid[0]}.
- R11: A fault that arrives while a fault is held leaves the saved status unchanged and sets overrun. Any cfg write to address 18 clears the status and overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | 1 = user mode, 0 = privileged |
| abort_o | output | 1 | Registered abort pulse |

## Verification
The bench probes the region edges. For both the 1 KB and the 1 MB size it uses the last word inside a region and the first word past it, and it programs a base with stray low bits to check that those bits are ignored. A mask shifted by one would move these edges, and a design that compared the stray bits would miss the hit. The bench overlaps a permissive region with a restrictive one in both orders. A design that let the highest-numbered region win, or that combined the rules of all matching regions, would abort in the wrong case or report the wrong index. Finally, the bench sends a second fault after the first, then clears the status. A design that overwrote the saved status would show the second address, and one that never set or never cleared overrun would fail the info-word compare.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int MPU_AW      = 32;
    localparam int MIN_SHIFT   = 10;
    localparam int MAX_CODE    = 10;
    localparam int BASE_W      = MPU_AW - MIN_SHIFT;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [3:0]        size;
        logic              en;
        logic              no_user;
        logic              no_write;
    } region_t;

    typedef enum logic {
        FS_EMPTY = 1'b0,
        FS_HELD  = 1'b1
    } fstate_t;
endpackage

// File: rtl/mpu_regs.sv
module mpu_regs
    import mpu_pkg::*;
#(
    parameter int NR = 16,
    parameter int CW = 5,
    parameter int IW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_addr,
    input  logic [MPU_AW-1:0] cfg_wdata,
    output logic [MPU_AW-1:0] cfg_rdata,
    output region_t           regs [NR],
    output logic              glob_en,
    output logic              per_nw,
    output logic              per_nu,
    output logic              clr,
    input  logic [MPU_AW-1:0] st_addr,
    input  logic              st_valid,
    input  logic              st_write,
    input  logic              st_user,
    input  logic              st_periph,
    input  logic [IW-1:0]     st_idx,
    input  logic              st_ovr
);
    localparam logic [CW-1:0] A_CTRL  = CW'(NR);
    localparam logic [CW-1:0] A_FADDR = CW'(NR + 1);
    localparam logic [CW-1:0] A_FINFO = CW'(NR + 2);

    generate
        for (genvar i = 0; i < NR; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[i] <= '0;
                end else if (cfg_we && cfg_addr == CW'(i)) begin
                    regs[i].base     <= cfg_wdata[MPU_AW-1:MIN_SHIFT];
                    regs[i].size     <= cfg_wdata[9:6];
                    regs[i].en       <= cfg_wdata[2];
                    regs[i].no_user  <= cfg_wdata[1];
                    regs[i].no_write <= cfg_wdata[0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            per_nw  <= 1'b0;
            per_nu  <= 1'b0;
        end else if (cfg_we && cfg_addr == A_CTRL) begin
            glob_en <= cfg_wdata[0];
            per_nw  <= cfg_wdata[1];
            per_nu  <= cfg_wdata[2];
        end
    end

    assign clr = cfg_we && (cfg_addr == A_FINFO);

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr < CW'(NR)) begin
            for (int i = 0; i < NR; i++) begin
                if (cfg_addr == CW'(i)) begin
                    cfg_rdata = {regs[i].base, regs[i].size, 3'b000,
                                 regs[i].en, regs[i].no_user, regs[i].no_write};
                end
            end
        end else if (cfg_addr == A_CTRL) begin
            cfg_rdata = {29'd0, per_nu, per_nw, glob_en};
        end else if (cfg_addr == A_FADDR) begin
            cfg_rdata = st_addr;
        end else if (cfg_addr == A_FINFO) begin
            cfg_rdata = '0;
            cfg_rdata[9]   = st_ovr;
            cfg_rdata[8:4] = 5'(st_idx);
            cfg_rdata[3]   = st_user;
            cfg_rdata[2]   = st_write;
            cfg_rdata[1]   = st_periph;
            cfg_rdata[0]   = st_valid;
        end
    end
endmodule

// File: rtl/mpu_match.sv
module mpu_match
    import mpu_pkg::*;
#(
    parameter int NR = 16,
    parameter int IW = 5
) (
    input  region_t           regs [NR],
    input  logic [MPU_AW-1:0] addr,
    input  logic              wr,
    input  logic              usr,
    output logic              hit_any,
    output logic              viol,
    output logic [IW-1:0]     idx
);
    logic [NR-1:0] hit;
    logic [NR-1:0] win;

    generate
        for (genvar i = 0; i < NR; i++) begin : g_cmp
            logic [3:0]        code;
            logic [MPU_AW-1:0] mask;
            logic [MPU_AW-1:0] base_full;
            always_comb begin
                code      = (regs[i].size > 4'(MAX_CODE)) ? 4'(MAX_CODE) : regs[i].size;
                mask      = {MPU_AW{1'b1}} << (MIN_SHIFT + int'(code));
                base_full = {regs[i].base, {MIN_SHIFT{1'b0}}};
                hit[i]    = regs[i].en && (((addr ^ base_full) & mask) == '0);
            end
        end
    endgenerate

    always_comb begin
        win     = '0;
        idx     = '0;
        viol    = 1'b0;
        hit_any = 1'b0;
        for (int i = 0; i < NR; i++) begin
            if (hit[i] && !hit_any) begin
                hit_any = 1'b1;
                win[i]  = 1'b1;
                idx     = IW'(i);
                viol    = (wr && regs[i].no_write) || (usr && regs[i].no_user);
            end
        end
    end

    // R6: priority selection picks at most one region
    always_comb begin
        a_r6_single_winner: assert ($onehot0(win));
    end
endmodule

// File: rtl/mpu_fault.sv
module mpu_fault
    import mpu_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              clr,
    input  logic [MPU_AW-1:0] f_addr,
    input  logic              f_write,
    input  logic              f_user,
    input  logic              f_periph,
    input  logic [IW-1:0]     f_idx,
    output logic              abort_o,
    output logic              st_valid,
    output logic [MPU_AW-1:0] st_addr,
    output logic              st_write,
    output logic              st_user,
    output logic              st_periph,
    output logic [IW-1:0]     st_idx,
    output logic              st_ovr
);
    fstate_t state, nstate;
    logic    capture;

    always_comb begin
        nstate = state;
        unique case (state)
            FS_EMPTY: if (fault) nstate = FS_HELD;
            FS_HELD:  if (clr)   nstate = fault ? FS_HELD : FS_EMPTY;
            default:  nstate = FS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_EMPTY;
        else        state <= nstate;
    end

    assign capture = fault && (state == FS_EMPTY || clr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_o   <= 1'b0;
            st_addr   <= '0;
            st_write  <= 1'b0;
            st_user   <= 1'b0;
            st_periph <= 1'b0;
            st_idx    <= '0;
            st_ovr    <= 1'b0;
        end else begin
            abort_o <= fault;
            if (capture) begin
                st_addr   <= f_addr;
                st_write  <= f_write;
                st_user   <= f_user;
                st_periph <= f_periph;
                st_idx    <= f_idx;
            end else if (clr) begin
                st_addr   <= '0;
                st_write  <= 1'b0;
                st_user   <= 1'b0;
                st_periph <= 1'b0;
                st_idx    <= '0;
            end
            if (clr)                              st_ovr <= 1'b0;
            else if (state == FS_HELD && fault)   st_ovr <= 1'b1;
        end
    end

    assign st_valid = (state == FS_HELD);

    // R11: a held fault keeps its address while no clear arrives
    a_r11_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_HELD && !clr) |=> $stable(st_addr));
    // R11: a second fault while held sets overrun
    a_r11_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_HELD && fault && !clr) |=> st_ovr);
    // R9: abort is a single-cycle pulse unless faults are back to back
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !fault) |=> !abort_o);
endmodule

// File: rtl/mpu_top.sv
module mpu_top
    import mpu_pkg::*;
#(
    parameter int NR = 16,
    parameter int CW = 5,
    parameter logic [3:0] PERIPH_TOP = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              abort_o
);
    localparam int IW = $clog2(NR + 1);

    region_t          regs [NR];
    logic             glob_en, per_nw, per_nu, clr;
    logic             hit_any, r_viol, p_hit, p_viol, fault, only_periph;
    logic [IW-1:0]    r_idx, f_idx;
    logic [31:0]      st_addr;
    logic             st_valid, st_write, st_user, st_periph, st_ovr;
    logic [IW-1:0]    st_idx;

    mpu_regs #(.NR(NR), .CW(CW), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .regs(regs),
        .glob_en(glob_en), .per_nw(per_nw), .per_nu(per_nu), .clr(clr),
        .st_addr(st_addr), .st_valid(st_valid), .st_write(st_write),
        .st_user(st_user), .st_periph(st_periph), .st_idx(st_idx), .st_ovr(st_ovr)
    );

    mpu_match #(.NR(NR), .IW(IW)) u_match (
        .regs(regs), .addr(acc_addr), .wr(acc_write), .usr(acc_user),
        .hit_any(hit_any), .viol(r_viol), .idx(r_idx)
    );

    assign p_hit       = (acc_addr[31:28] == PERIPH_TOP);
    assign p_viol      = p_hit && ((acc_write && per_nw) || (acc_user && per_nu));
    assign only_periph = p_viol && !(hit_any && r_viol);
    assign f_idx       = only_periph ? IW'(NR) : r_idx;
    assign fault       = acc_valid && glob_en && ((hit_any && r_viol) || p_viol);

    mpu_fault #(.IW(IW)) u_fault (
        .clk(clk), .rst_n(rst_n), .fault(fault), .clr(clr),
        .f_addr(acc_addr), .f_write(acc_write), .f_user(acc_user),
        .f_periph(only_periph), .f_idx(f_idx), .abort_o(abort_o),
        .st_valid(st_valid), .st_addr(st_addr), .st_write(st_write),
        .st_user(st_user), .st_periph(st_periph), .st_idx(st_idx), .st_ovr(st_ovr)
    );

    // R9: an abort always follows a valid access
    a_r9_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(acc_valid));
    // R8: a disabled unit never aborts
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(glob_en) |-> !abort_o);
endmodule

// File: tb/tb_mpu_top.sv
module tb_mpu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_user = 1'b0;
    logic        abort_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mpu_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_user(acc_user),
        .abort_o(abort_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_cfg(input logic [4:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] rgn(input logic [31:0] base, input int code,
                                        input bit en, input bit nu, input bit nw);
        return {base[31:10], 4'(code), 3'b000, en, nu, nw};
    endfunction

    // one access; returns abort seen one cycle later, then checks pulse width
    task automatic access(input logic [31:0] a, input bit w, input bit u, output bit ab);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_user = u;
        @(negedge clk);
        acc_valid = 1'b0;
        ab = abort_o;
        @(negedge clk);
        chk("R9 pulse low after", {31'd0, abort_o}, 32'd0);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 16; i++) wr_cfg(5'(i), 32'd0);
        wr_cfg(5'd18, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 abort", {31'd0, abort_o}, 32'd0);
        rd_cfg(5'd16, d); chk("R1 ctrl", d, 32'd0);
        rd_cfg(5'd18, d); chk("R1 info", d, 32'd0);
        rd_cfg(5'd3, d);  chk("R1 region", d, 32'd0);
    endtask

    task automatic t_program();
        logic [31:0] d;
        wr_cfg(5'd7, rgn(32'h0040_0000, 5, 1, 1, 0));
        rd_cfg(5'd7, d);
        chk("R2 region word", d, 32'h0040_0146);
        wr_cfg(5'd16, 32'd1);
        rd_cfg(5'd16, d);
        chk("R2 ctrl word", d, 32'd1);
        wr_cfg(5'd7, 32'd0);
    endtask

    task automatic t_disabled();
        bit ab;
        wr_cfg(5'd16, 32'd0);
        wr_cfg(5'd0, rgn(32'h0000_1000, 2, 1, 1, 1));
        access(32'h0000_1004, 1, 1, ab);
        chk("R8 off no abort", {31'd0, ab}, 32'd0);
        wr_cfg(5'd16, 32'd1);
        clear_all();
    endtask

    task automatic t_nowrite();
        bit ab;
        logic [31:0] d;
        wr_cfg(5'd2, rgn(32'h0000_4000, 2, 1, 0, 1));
        access(32'h0000_4010, 0, 1, ab);
        chk("R3 read allowed", {31'd0, ab}, 32'd0);
        access(32'h0000_4010, 1, 0, ab);
        chk("R3 write aborts", {31'd0, ab}, 32'd1);
        rd_cfg(5'd17, d); chk("R10 fault addr", d, 32'h0000_4010);
        rd_cfg(5'd18, d); chk("R10 fault info", d, 32'h0000_0025);
        clear_all();
    endtask

    task automatic t_nouser();
        bit ab;
        logic [31:0] d;
        wr_cfg(5'd9, rgn(32'h0000_8000, 0, 1, 1, 0));
        access(32'h0000_8000, 1, 0, ab);
        chk("R4 priv allowed", {31'd0, ab}, 32'd0);
        access(32'h0000_8000, 0, 1, ab);
        chk("R4 user aborts", {31'd0, ab}, 32'd1);
        rd_cfg(5'd18, d); chk("R4 info", d, 32'h0000_0099);
        clear_all();
    endtask

    task automatic t_sizes();
        bit ab;
        logic [31:0] d;
        wr_cfg(5'd1, rgn(32'h0000_2000, 0, 1, 0, 1));
        access(32'h0000_23FC, 1, 0, ab); chk("R5 1K last word", {31'd0, ab}, 32'd1);
        wr_cfg(5'd18, 0);
        access(32'h0000_2400, 1, 0, ab); chk("R5 1K past end", {31'd0, ab}, 32'd0);
        wr_cfg(5'd1, rgn(32'h0010_0000, 10, 1, 0, 1));
        access(32'h001F_FFFC, 1, 0, ab); chk("R5 1M last word", {31'd0, ab}, 32'd1);
        wr_cfg(5'd18, 0);
        access(32'h0020_0000, 1, 0, ab); chk("R5 1M past end", {31'd0, ab}, 32'd0);
        access(32'h000F_FFFC, 1, 0, ab); chk("R5 1M before base", {31'd0, ab}, 32'd0);
        wr_cfg(5'd1, rgn(32'h0010_0000, 15, 1, 0, 1));
        access(32'h0020_0000, 1, 0, ab); chk("R5 code clamp", {31'd0, ab}, 32'd0);
        wr_cfg(5'd1, rgn(32'h0000_5000, 3, 1, 0, 1));
        access(32'h0000_4004, 1, 0, ab); chk("R5 low base bits ignored", {31'd0, ab}, 32'd1);
        rd_cfg(5'd18, d); chk("R5 info idx1", d, 32'h0000_0015);
        clear_all();
    endtask

    task automatic t_priority();
        bit ab;
        logic [31:0] d;
        wr_cfg(5'd0, rgn(32'h0000_8000, 2, 1, 0, 0));
        wr_cfg(5'd1, rgn(32'h0000_8000, 2, 1, 1, 1));
        access(32'h0000_8100, 1, 1, ab); chk("R6 low open wins", {31'd0, ab}, 32'd0);
        clear_all();
        wr_cfg(5'd3, rgn(32'h0000_8000, 2, 1, 0, 1));
        wr_cfg(5'd5, rgn(32'h0000_8000, 4, 1, 0, 0));
        access(32'h0000_8100, 1, 0, ab); chk("R6 low strict wins", {31'd0, ab}, 32'd1);
        rd_cfg(5'd18, d); chk("R6 index 3", d, 32'h0000_0035);
        wr_cfg(5'd18, 0);
        access(32'h0009_0000, 1, 1, ab); chk("R6 unmatched allowed", {31'd0, ab}, 32'd0);
        clear_all();
    endtask

    task automatic t_periph();
        bit ab;
        logic [31:0] d;
        wr_cfg(5'd16, 32'h0000_0003);
        access(32'hF000_0010, 0, 1, ab); chk("R7 periph read ok", {31'd0, ab}, 32'd0);
        access(32'hF000_0010, 1, 0, ab); chk("R7 periph write aborts", {31'd0, ab}, 32'd1);
        rd_cfg(5'd18, d); chk("R7 info idx16", d, 32'h0000_0107);
        access(32'hE000_0010, 1, 0, ab); chk("R7 outside periph", {31'd0, ab}, 32'd0);
        wr_cfg(5'd16, 32'h0000_0001);
        clear_all();
    endtask

    task automatic t_overrun();
        bit ab;
        logic [31:0] d;
        wr_cfg(5'd4, rgn(32'h0003_0000, 6, 1, 1, 1));
        access(32'h0003_0100, 1, 0, ab); chk("R9 first abort", {31'd0, ab}, 32'd1);
        access(32'h0003_0200, 0, 1, ab); chk("R11 second abort", {31'd0, ab}, 32'd1);
        rd_cfg(5'd17, d); chk("R11 addr kept", d, 32'h0003_0100);
        rd_cfg(5'd18, d); chk("R11 overrun set", d, 32'h0000_0245);
        wr_cfg(5'd18, 0);
        rd_cfg(5'd18, d); chk("R11 cleared", d, 32'd0);
        access(32'h0003_0300, 0, 1, ab);
        rd_cfg(5'd17, d); chk("R10 recapture addr", d, 32'h0003_0300);
        rd_cfg(5'd18, d); chk("R10 recapture info", d, 32'h0000_0049);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_disabled();
        t_nowrite();
        t_nouser();
        t_sizes();
        t_priority();
        t_periph();
        t_overrun();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule